// File: doc/BRIEF.md
# Serial Transmit Framer with Stick Parity

This block turns parallel data bytes into asynchronous serial frames on a single TX line. A byte is handed over with a valid/ready handshake. The framer then sends a start bit, the configured number of data bits least-significant first, an optional parity bit, and one or two stop bits. The line idles high. Bit timing comes from an external baud-tick enable. Every bit lasts a fixed number of those ticks.

Line-control inputs select the word length, the stop-bit count and the parity handling. The parity bit can be odd, even, or held at a constant mark or space level. The framer latches all of these settings, together with the data, at the moment a byte is accepted. A break input pulls the line to space at once, whatever the sequencer is doing. The frame sequence keeps running underneath, so when break is released the line shows the bit that is in progress at that moment.

Top module: `uart_stick_tx`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `tx_o` is 1 (unless break is active), `ready_o` is 1 and `busy_o` is 0.
- R2: A frame is one start bit of 0, then the data bits LSB first, then the stop bits at 1. `word_len_i` sets the data-bit count: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8. `two_stop_i`=1 gives two stop bits and 0 gives one.
- R3: Each frame bit lasts exactly OVS_TICKS cycles in which `baud_tick_i` is 1. `ready_o` is 0 and `busy_o` is 1 from the cycle after acceptance until the tick that ends the last stop bit.
- R4: With `par_en_i`=0 no parity bit is sent, whatever `par_type_i` and `par_stick_i` hold.
- R5: With `par_en_i`=1 and `par_stick_i`=0, the parity bit follows the last data bit. `par_type_i`=0 gives odd parity and 1 gives even parity. Parity is computed only over the configured data bits.
- R6: With `par_en_i`=1 and `par_stick_i`=1, the parity bit is 1 when `par_type_i`=0 and 0 when `par_type_i`=1.
- R7: Data and all line-control inputs are sampled at acceptance (`valid_i` and `ready_o` both 1 at a clock edge). Changes made to them during the frame do not affect it.
- R8: While `break_i` is 1, `tx_o` is 0 in every state. Break does not stop or shift the frame sequence. After release, `tx_o` shows the bit currently being sent.
- R9: `valid_i` asserted while a frame is in progress is ignored: no second frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Byte to transmit |
| valid_i | input | 1 | Data valid |
| ready_o | output | 1 | Framer can accept a byte |
| baud_tick_i | input | 1 | Baud-rate tick enable |
| word_len_i | input | WLEN_W | Data-bit count minus MIN_BITS |
| two_stop_i | input | 1 | Two stop bits when 1 |
| par_en_i | input | 1 | Parity bit enable |
| par_type_i | input | 1 | 0 odd / mark, 1 even / space |
| par_stick_i | input | 1 | Force parity to a constant level |
| break_i | input | 1 | Hold TX at space |
| tx_o | output | 1 | Serial line |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench builds the framer with OVS_TICKS=4 and an eight-bit word, and raises the baud tick every third clock. A full twelve-bit frame therefore takes only 144 cycles. This makes it practical to sample every bit mid-period and to cover all four word lengths, both stop counts and all parity modes. With four ticks per bit, a miscounted tick moves every later sample, so bit-duration faults show up as frame mismatches. Break is asserted over chosen bits inside a frame and released before the frame ends, to confirm that the underlying sequence carried on.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    PAR_NONE,
    PAR_ODD,
    PAR_EVEN,
    PAR_MARK,
    PAR_SPACE
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  function automatic par_mode_e par_decode(logic en, logic stick, logic typ);
    if (!en)        return PAR_NONE;
    else if (stick) return typ ? PAR_SPACE : PAR_MARK;
    else            return typ ? PAR_EVEN : PAR_ODD;
  endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int OVS_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic bit_end_o
);
  localparam int CW = (OVS_TICKS > 2) ? $clog2(OVS_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign bit_end_o = en_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (en_i && tick_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tx_parity.sv
module tx_parity
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  par_mode_e         mode_i,
  output logic              par_o
);
  logic [DATA_W-1:0] mask;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (CNT_W'(g) < nbits_i);
  end

  logic xr;
  assign xr = ^(data_i & mask);

  always_comb begin
    unique case (mode_i)
      PAR_ODD:   par_o = ~xr;
      PAR_EVEN:  par_o = xr;
      PAR_MARK:  par_o = 1'b1;
      PAR_SPACE: par_o = 1'b0;
      default:   par_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic              two_stop_i,
  input  logic              par_en_i,
  input  logic              par_bit_i,
  input  logic              bit_end_i,
  output logic              line_o,
  output logic              busy_o
);
  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  idx_q, nbits_q;
  logic              two_q, pen_q, pbit_q;

  assign busy_o = (state_q != ST_IDLE);

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = shreg_q[0];
      ST_PAR:   line_o = pbit_q;
      default:  line_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
      nbits_q <= '0;
      two_q   <= 1'b0;
      pen_q   <= 1'b0;
      pbit_q  <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load_i) begin
          shreg_q <= data_i;
          nbits_q <= nbits_i;
          two_q   <= two_stop_i;
          pen_q   <= par_en_i;
          pbit_q  <= par_bit_i;
          idx_q   <= '0;
          state_q <= ST_START;
        end
        ST_START: if (bit_end_i) state_q <= ST_DATA;
        ST_DATA: if (bit_end_i) begin
          shreg_q <= shreg_q >> 1;
          if (idx_q == nbits_q - 1'b1) begin
            idx_q   <= '0;
            state_q <= pen_q ? ST_PAR : ST_STOP;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_PAR: if (bit_end_i) state_q <= ST_STOP;
        ST_STOP: if (bit_end_i) begin
          if (idx_q == CNT_W'(two_q)) state_q <= ST_IDLE;
          else                        idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_stick_tx.sv
module uart_stick_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MIN_BITS  = 5,
  parameter int OVS_TICKS = 16,
  parameter int WLEN_W    = (DATA_W - MIN_BITS > 0) ? $clog2(DATA_W - MIN_BITS + 1) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              baud_tick_i,
  input  logic [WLEN_W-1:0] word_len_i,
  input  logic              two_stop_i,
  input  logic              par_en_i,
  input  logic              par_type_i,
  input  logic              par_stick_i,
  input  logic              break_i,
  output logic              tx_o,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic             load, bit_end, line, busy;
  logic [CNT_W-1:0] nbits;
  logic             par_bit;
  par_mode_e        pmode;

  assign nbits   = CNT_W'(MIN_BITS) + CNT_W'(word_len_i);
  assign pmode   = par_decode(par_en_i, par_stick_i, par_type_i);
  assign ready_o = ~busy;
  assign busy_o  = busy;
  assign load    = valid_i & ~busy;
  // break overrides the line, sequencer keeps running
  assign tx_o    = line & ~break_i;

  tx_parity #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_par (
    .data_i (data_i),
    .nbits_i(nbits),
    .mode_i (pmode),
    .par_o  (par_bit)
  );

  tx_bit_timer #(.OVS_TICKS(OVS_TICKS)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (busy),
    .clr_i    (load),
    .tick_i   (baud_tick_i),
    .bit_end_o(bit_end)
  );

  tx_frame_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .data_i    (data_i),
    .nbits_i   (nbits),
    .two_stop_i(two_stop_i),
    .par_en_i  (par_en_i),
    .par_bit_i (par_bit),
    .bit_end_i (bit_end),
    .line_o    (line),
    .busy_o    (busy)
  );
endmodule

// File: rtl/uart_stick_tx_chk.sv
module uart_stick_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic busy_o,
  input logic baud_tick_i,
  input logic break_i,
  input logic tx_o
);
  // R1
  idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !break_i) |-> tx_o);

  // R2
  start_bit_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !tx_o);

  // R3
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (busy_o && !ready_o));

  // R3
  no_end_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !baud_tick_i) |=> busy_o);

  // R8
  break_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_i |-> !tx_o);
endmodule

bind uart_stick_tx uart_stick_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .ready_o    (ready_o),
  .busy_o     (busy_o),
  .baud_tick_i(baud_tick_i),
  .break_i    (break_i),
  .tx_o       (tx_o)
);

// File: tb/uart_stick_tx_tb_top.sv
`timescale 1ns/1ps
module uart_stick_tx_tb_top;
  localparam int OVS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data = '0;
  logic       valid = 1'b0;
  logic       ready, tx, busy;
  logic       tick = 1'b0;
  logic [1:0] wlen = '0;
  logic       two_stop = 1'b0, pen = 1'b0, ptype = 1'b0, pstick = 1'b0, brk = 1'b0;

  int checks = 0;
  int fails  = 0;
  int div    = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    div  = (div == 2) ? 0 : div + 1;
    tick = (div == 0);
  end

  uart_stick_tx #(.DATA_W(8), .MIN_BITS(5), .OVS_TICKS(OVS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid), .ready_o(ready),
    .baud_tick_i(tick), .word_len_i(wlen), .two_stop_i(two_stop), .par_en_i(pen),
    .par_type_i(ptype), .par_stick_i(pstick), .break_i(brk), .tx_o(tx), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  // sends one frame and checks every bit mid-period
  task automatic run_frame(input logic [7:0] d, input logic [1:0] wl, input logic ts,
                           input logic pe, input logic pt, input logic ps,
                           input logic [11:0] bmask, input bit disturb, input string req);
    logic [11:0] exp_bits, got_bits;
    int nb, n;
    logic [7:0] m;
    logic par;
    int rdy_bad;
    nb = 5 + int'(wl);
    m = 8'hFF >> (8 - nb);
    par = pe ? (ps ? ~pt : (pt ? ^(d & m) : ~^(d & m))) : 1'b1;
    exp_bits = '0;
    exp_bits[0] = 1'b0;
    for (int i = 0; i < nb; i++) exp_bits[1+i] = d[i];
    n = 1 + nb;
    if (pe) begin exp_bits[n] = par; n++; end
    exp_bits[n] = 1'b1; n++;
    if (ts) begin exp_bits[n] = 1'b1; n++; end
    exp_bits = exp_bits & ~bmask;
    got_bits = '0;
    rdy_bad = 0;

    @(negedge clk);
    chk(ready === 1'b1, req, "ready before send", int'(ready), 1);
    data = d; wlen = wl; two_stop = ts; pen = pe; ptype = pt; pstick = ps; valid = 1'b1;
    @(posedge clk);
    #1 valid = 1'b0;
    if (disturb) begin
      data = ~d; wlen = ~wl; two_stop = ~ts; pen = ~pe; ptype = ~pt; pstick = ~ps;
    end
    for (int k = 0; k < n; k++) begin
      wait_ticks(2);
      @(negedge clk);
      brk = bmask[k];
      #1;
      got_bits[k] = tx;
      if (ready !== 1'b0 || busy !== 1'b1) rdy_bad++;
      if (disturb && k == 2) begin
        valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
      end
      wait_ticks(OVS - 2);
    end
    @(negedge clk);
    brk = 1'b0;
    #1;
    chk(got_bits === exp_bits, req, "frame bits", int'(got_bits), int'(exp_bits));
    chk(rdy_bad == 0, "R3", "ready low/busy high during frame", rdy_bad, 0);
    chk(ready === 1'b1 && busy === 1'b0 && tx === 1'b1, "R3", "idle after last stop",
        int'({ready, busy, tx}), 3'b101);
    if (disturb) begin
      int bad = 0;
      for (int k = 0; k < 3 * OVS; k++) begin
        wait_ticks(1);
        @(negedge clk);
        #1;
        if (tx !== 1'b1 || ready !== 1'b1) bad++;
      end
      chk(bad == 0, "R9", "no second frame after busy valid", bad, 0);
    end
    data = '0; wlen = '0; two_stop = 0; pen = 0; ptype = 0; pstick = 0;
  endtask

  task automatic test_reset;
    #1;
    chk(tx === 1'b1 && ready === 1'b1 && busy === 1'b0, "R1", "in reset",
        int'({tx, ready, busy}), 3'b110);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(tx === 1'b1 && ready === 1'b1 && busy === 1'b0, "R1", "idle after reset",
        int'({tx, ready, busy}), 3'b110);
  endtask

  task automatic test_formats;
    run_frame(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, '0, 0, "R2");
    run_frame(8'h3C, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, '0, 0, "R2");
    run_frame(8'h16, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 0, "R2");
  endtask

  task automatic test_parity;
    run_frame(8'h4B, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, '0, 0, "R5");
    run_frame(8'h4B, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, '0, 0, "R5");
    // upper bits outside the 5-bit word must not enter the parity
    run_frame(8'hE3, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, '0, 0, "R5");
    run_frame(8'hE3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 0, "R5");
    run_frame(8'h00, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, '0, 0, "R6");
    run_frame(8'hFF, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, '0, 0, "R6");
    run_frame(8'h29, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, '0, 0, "R6");
    run_frame(8'h5A, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, '0, 0, "R4");
    run_frame(8'h07, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, '0, 0, "R4");
  endtask

  task automatic test_break;
    @(negedge clk);
    brk = 1'b1;
    #1;
    chk(tx === 1'b0 && ready === 1'b1, "R8", "break in idle", int'({tx, ready}), 2'b01);
    @(negedge clk);
    brk = 1'b0;
    #1;
    chk(tx === 1'b1, "R8", "release in idle", int'(tx), 1);
    run_frame(8'hFF, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 12'b0000_0011_1100, 0, "R8");
    run_frame(8'hC7, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 12'b0010_0000_0001, 0, "R8");
  endtask

  task automatic test_sampled;
    run_frame(8'h9C, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1, "R7");
  endtask

  initial begin
    test_reset();
    test_formats();
    test_parity();
    test_break();
    test_sampled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule